// File: doc/BRIEF.md
# Waveform Timer Channel

This block is one counter channel of a general-purpose timer, used only to generate waveforms. A counter whose width is a parameter advances on a qualified count tick. It is compared against three compare values, A, B and C. The configuration inputs set the following:

- the counting mode, which is up only or up/down, with or without an automatic restart when the counter reaches C;
- what the C match does to the counter clock, which can be to stop it or to disable it;
- what the A match and the B match do to the two output pins.

An external event can restart the counter and its clock. The event is picked from the B pin or one of three external lines, and its edge is selectable. When the B pin is picked as the event, it turns into an input.

A restart is requested by a software pulse, by a detected external event (when enabled) or by the automatic C-match restart. The request is held until the next counting tick, which loads zero and sets the direction to up. The block is driven by a parent that owns the configuration and the compare values and supplies the count tick.

Top module: `tc_wave_channel`

## Requirements
- R1: After reset the counter is 0, the direction is up, both pins are low, all match flags are low, and the counter clock is both disabled and stopped.
- R2: The counter changes only on a counting tick, meaning `tick_i` is high while the clock is enabled and running. A restart request (`sw_trig_i` also starts the clock) loads 0 on the next counting tick.
- R3: `cfg_wave_sel_i` bit 1 selects the automatic restart on C and bit 0 selects up/down counting. With value 0 the counter counts 0,1,2,… past C and wraps at the maximum.
- R4: With value 1 (up/down, no automatic restart) the counter turns down on reaching C or the maximum, and turns up on reaching 0.
- R5: With values 2 and 3 the counter restarts after reaching C, giving a period of C+1 ticks. It does not turn down at C.
- R6: With `cfg_stop_c_i` set, the clock stops when the counter reaches C and the counter holds C. A later restart request resumes counting from 0.
- R7: With `cfg_dis_c_i` set, the clock is disabled when the counter reaches C. A restart request alone does not resume counting. `en_cmd_i` does resume it, and a pending request then loads 0.
- R8: On the A match, `cfg_a_match_i` acts on pin A. The codes are 0 none, 1 set, 2 clear, 3 toggle.
- R9: `cfg_evt_src_i` picks the event signal: 0 is the B pin, and 1, 2 and 3 are external lines 0, 1 and 2. `cfg_evt_edge_i` picks the edge: 0 none, 1 rising, 2 falling, 3 both. The signal passes through two sync flops, so a change acts at the third clock edge after it.
- R10: With `cfg_trig_en_i` = 1 a detected event requests a restart and starts the clock. With 0 the counter is unaffected and only pin A reacts, through `cfg_a_evt_i` (same codes as R8). The event action takes precedence over an A match in the same cycle.
- R11: With `cfg_evt_src_i` = 0 the B pin is an input: `b_oe_o` is 0, `match_b_o` stays low and `b_out_o` holds. Otherwise `b_oe_o` is 1 and the B match applies `cfg_b_match_i` (codes as R8).
- R12: A detected event with restart enabled wins over a stop-on-C occurring in the same cycle, so the counter restarts instead of stopping.
- R13: Each match flag pulses high for the one cycle in which the counter has just taken the matching compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable tick |
| sw_trig_i | input | 1 | Software restart pulse |
| en_cmd_i | input | 1 | Explicit counter clock enable pulse |
| xc_i | input | 3 | External event lines 0..2 |
| b_in_i | input | 1 | B pin input level |
| cfg_wave_sel_i | input | 2 | Counting mode |
| cfg_evt_edge_i | input | 2 | Event edge selection |
| cfg_evt_src_i | input | 2 | Event signal selection |
| cfg_trig_en_i | input | 1 | Event restarts counter |
| cfg_stop_c_i | input | 1 | Stop clock on C match |
| cfg_dis_c_i | input | 1 | Disable clock on C match |
| cfg_a_match_i | input | 2 | A match action on pin A |
| cfg_a_evt_i | input | 2 | Event action on pin A |
| cfg_b_match_i | input | 2 | B match action on pin B |
| ra_i | input | CNT_W | Compare value A |
| rb_i | input | CNT_W | Compare value B |
| rc_i | input | CNT_W | Compare value C |
| cnt_o | output | CNT_W | Counter value |
| a_out_o | output | 1 | Pin A level |
| b_out_o | output | 1 | Pin B output level |
| b_oe_o | output | 1 | Pin B drive enable |
| match_a_o | output | 1 | A match pulse |
| match_b_o | output | 1 | B match pulse |
| match_c_o | output | 1 | C match pulse |

## Verification
A wrong direction bit or a lost restart request shows on `cnt_o` at the very next counting tick, as a wrong value in a known sequence. A wrong run or enable bit shows as a counter that moves or freezes when it should not, within one tick of the C match. A synchronizer with the wrong depth moves the restart by a cycle, and this is seen as a wrong count exactly at the expected restart edge. Pin and flag state errors show in the cycle right after the matching count is reached.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'd0,
        PIN_SET  = 2'd1,
        PIN_CLR  = 2'd2,
        PIN_FLIP = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    function automatic logic pin_apply(input logic cur, input logic [1:0] act);
        case (pin_act_e'(act))
            PIN_SET:  return 1'b1;
            PIN_CLR:  return 1'b0;
            PIN_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/tcw_evt_detect.sv
module tcw_evt_detect
    import tcw_pkg::*;
#(
    parameter int N_XC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_XC-1:0] xc_i,
    input  logic            b_in_i,
    input  logic [1:0]      src_i,
    input  logic [1:0]      edge_i,
    output logic            hit_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  sel_sig;
    logic  rise, fall;

    always_comb begin
        sel_sig = b_in_i;
        for (int i = 0; i < N_XC; i++) begin
            if (int'(src_i) == i + 1) sel_sig = xc_i[i];
        end
    end

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = sel_sig;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
        rise      = sync_q.s2 & ~sync_q.s3;
        fall      = ~sync_q.s2 & sync_q.s3;
        case (edge_sel_e'(edge_i))
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_ANY:  hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

endmodule

// File: rtl/tcw_count_core.sv
module tcw_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sw_trig_i,
    input  logic             en_cmd_i,
    input  logic             evt_trig_i,
    input  logic [1:0]       mode_i,
    input  logic             stop_c_i,
    input  logic             dis_c_i,
    input  logic [CNT_W-1:0] ra_i,
    input  logic [CNT_W-1:0] rb_i,
    input  logic [CNT_W-1:0] rc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_a_o,
    output logic             hit_b_o,
    output logic             hit_c_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             pend;
        logic             run;
        logic             en;
    } core_t;

    core_t            st_d, st_q;
    logic             step;
    logic             auto_rst;
    logic             updown;
    logic             ext_req;
    logic [CNT_W-1:0] nxt;

    assign auto_rst = mode_i[1];
    assign updown   = mode_i[0];
    assign ext_req  = sw_trig_i | evt_trig_i;

    always_comb begin
        st_d    = st_q;
        step    = tick_i & st_q.en & st_q.run;
        nxt     = st_q.cnt;
        hit_a_o = 1'b0;
        hit_b_o = 1'b0;
        hit_c_o = 1'b0;
        if (step) begin
            if (st_q.pend) begin
                nxt       = '0;
                st_d.down = 1'b0;
            end else if (!updown) begin
                nxt = st_q.cnt + CNT_ONE;
            end else if (st_q.down) begin
                nxt = st_q.cnt - CNT_ONE;
                if (nxt == '0) st_d.down = 1'b0;
            end else begin
                nxt = st_q.cnt + CNT_ONE;
                if ((!auto_rst && nxt == rc_i) || nxt == CNT_MAX) st_d.down = 1'b1;
            end
            st_d.cnt = nxt;
            hit_a_o  = (nxt == ra_i);
            hit_b_o  = (nxt == rb_i);
            hit_c_o  = (nxt == rc_i);
        end

        st_d.pend = (st_q.pend & ~step) | ext_req | (hit_c_o & auto_rst);

        if (ext_req)                  st_d.run = 1'b1;
        else if (hit_c_o && stop_c_i) st_d.run = 1'b0;

        if (en_cmd_i)                st_d.en = 1'b1;
        else if (hit_c_o && dis_c_i) st_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/tcw_wave_out.sv
module tcw_wave_out
    import tcw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_a_i,
    input  logic       hit_b_i,
    input  logic       hit_c_i,
    input  logic       evt_hit_i,
    input  logic [1:0] evt_src_i,
    input  logic [1:0] a_match_i,
    input  logic [1:0] a_evt_i,
    input  logic [1:0] b_match_i,
    output logic       a_out_o,
    output logic       b_out_o,
    output logic       b_oe_o,
    output logic       flag_a_o,
    output logic       flag_b_o,
    output logic       flag_c_o
);

    typedef struct packed {
        logic a;
        logic b;
        logic fa;
        logic fb;
        logic fc;
    } pin_t;

    pin_t pin_d, pin_q;
    logic b_drv;

    assign b_drv = (evt_src_i != 2'd0);

    always_comb begin
        pin_d    = pin_q;
        pin_d.fa = hit_a_i;
        pin_d.fb = hit_b_i & b_drv;
        pin_d.fc = hit_c_i;
        if (evt_hit_i && pin_act_e'(a_evt_i) != PIN_KEEP) pin_d.a = pin_apply(pin_q.a, a_evt_i);
        else if (hit_a_i)                                 pin_d.a = pin_apply(pin_q.a, a_match_i);
        if (b_drv && hit_b_i) pin_d.b = pin_apply(pin_q.b, b_match_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign a_out_o  = pin_q.a;
    assign b_out_o  = pin_q.b;
    assign b_oe_o   = b_drv;
    assign flag_a_o = pin_q.fa;
    assign flag_b_o = pin_q.fb;
    assign flag_c_o = pin_q.fc;

endmodule

// File: rtl/tc_wave_channel.sv
module tc_wave_channel #(
    parameter int CNT_W = 16,
    parameter int N_XC  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sw_trig_i,
    input  logic             en_cmd_i,
    input  logic [N_XC-1:0]  xc_i,
    input  logic             b_in_i,
    input  logic [1:0]       cfg_wave_sel_i,
    input  logic [1:0]       cfg_evt_edge_i,
    input  logic [1:0]       cfg_evt_src_i,
    input  logic             cfg_trig_en_i,
    input  logic             cfg_stop_c_i,
    input  logic             cfg_dis_c_i,
    input  logic [1:0]       cfg_a_match_i,
    input  logic [1:0]       cfg_a_evt_i,
    input  logic [1:0]       cfg_b_match_i,
    input  logic [CNT_W-1:0] ra_i,
    input  logic [CNT_W-1:0] rb_i,
    input  logic [CNT_W-1:0] rc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             a_out_o,
    output logic             b_out_o,
    output logic             b_oe_o,
    output logic             match_a_o,
    output logic             match_b_o,
    output logic             match_c_o
);

    logic evt_hit;
    logic hit_a, hit_b, hit_c;

    tcw_evt_detect #(.N_XC(N_XC)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .xc_i   (xc_i),
        .b_in_i (b_in_i),
        .src_i  (cfg_evt_src_i),
        .edge_i (cfg_evt_edge_i),
        .hit_o  (evt_hit)
    );

    tcw_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .sw_trig_i  (sw_trig_i),
        .en_cmd_i   (en_cmd_i),
        .evt_trig_i (evt_hit & cfg_trig_en_i),
        .mode_i     (cfg_wave_sel_i),
        .stop_c_i   (cfg_stop_c_i),
        .dis_c_i    (cfg_dis_c_i),
        .ra_i       (ra_i),
        .rb_i       (rb_i),
        .rc_i       (rc_i),
        .cnt_o      (cnt_o),
        .hit_a_o    (hit_a),
        .hit_b_o    (hit_b),
        .hit_c_o    (hit_c)
    );

    tcw_wave_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_a_i   (hit_a),
        .hit_b_i   (hit_b),
        .hit_c_i   (hit_c),
        .evt_hit_i (evt_hit),
        .evt_src_i (cfg_evt_src_i),
        .a_match_i (cfg_a_match_i),
        .a_evt_i   (cfg_a_evt_i),
        .b_match_i (cfg_b_match_i),
        .a_out_o   (a_out_o),
        .b_out_o   (b_out_o),
        .b_oe_o    (b_oe_o),
        .flag_a_o  (match_a_o),
        .flag_b_o  (match_b_o),
        .flag_c_o  (match_c_o)
    );

endmodule

// File: rtl/tc_wave_channel_chk.sv
module tc_wave_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             en_cmd_i,
    input logic             evt_hit,
    input logic [1:0]       cfg_evt_src_i,
    input logic             cfg_dis_c_i,
    input logic [1:0]       cfg_a_match_i,
    input logic [CNT_W-1:0] ra_i,
    input logic [CNT_W-1:0] rc_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             a_out_o,
    input logic             match_a_o,
    input logic             match_b_o,
    input logic             match_c_o
);

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> $stable(cnt_o)); // R2

    AST_C_FLAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        match_c_o |-> cnt_o == $past(rc_i)); // R13

    AST_A_FLAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        match_a_o |-> cnt_o == $past(ra_i)); // R13

    AST_DIS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_c_o && $past(cfg_dis_c_i) && !$past(en_cmd_i)) |=> $stable(cnt_o)); // R7

    AST_B_INPUT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_evt_src_i == 2'd0 && $past(cfg_evt_src_i) == 2'd0) |-> !match_b_o); // R11

    AST_A_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a_o && $past(cfg_a_match_i) == 2'd3 && !$past(evt_hit))
            |-> a_out_o != $past(a_out_o)); // R8

endmodule

bind tc_wave_channel tc_wave_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .en_cmd_i      (en_cmd_i),
    .evt_hit       (evt_hit),
    .cfg_evt_src_i (cfg_evt_src_i),
    .cfg_dis_c_i   (cfg_dis_c_i),
    .cfg_a_match_i (cfg_a_match_i),
    .ra_i          (ra_i),
    .rc_i          (rc_i),
    .cnt_o         (cnt_o),
    .a_out_o       (a_out_o),
    .match_a_o     (match_a_o),
    .match_b_o     (match_b_o),
    .match_c_o     (match_c_o)
);

// File: tb/tc_wave_channel_tb.sv
module tc_wave_channel_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick_i, sw_trig_i, en_cmd_i, b_in_i;
    logic [2:0]   xc_i;
    logic [1:0]   cfg_wave_sel_i, cfg_evt_edge_i, cfg_evt_src_i;
    logic         cfg_trig_en_i, cfg_stop_c_i, cfg_dis_c_i;
    logic [1:0]   cfg_a_match_i, cfg_a_evt_i, cfg_b_match_i;
    logic [W-1:0] ra_i, rb_i, rc_i, cnt_o;
    logic         a_out_o, b_out_o, b_oe_o, match_a_o, match_b_o, match_c_o;

    int runs  = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tc_wave_channel #(.CNT_W(W), .N_XC(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sw_trig_i(sw_trig_i),
        .en_cmd_i(en_cmd_i), .xc_i(xc_i), .b_in_i(b_in_i),
        .cfg_wave_sel_i(cfg_wave_sel_i), .cfg_evt_edge_i(cfg_evt_edge_i),
        .cfg_evt_src_i(cfg_evt_src_i), .cfg_trig_en_i(cfg_trig_en_i),
        .cfg_stop_c_i(cfg_stop_c_i), .cfg_dis_c_i(cfg_dis_c_i),
        .cfg_a_match_i(cfg_a_match_i), .cfg_a_evt_i(cfg_a_evt_i),
        .cfg_b_match_i(cfg_b_match_i), .ra_i(ra_i), .rb_i(rb_i), .rc_i(rc_i),
        .cnt_o(cnt_o), .a_out_o(a_out_o), .b_out_o(b_out_o), .b_oe_o(b_oe_o),
        .match_a_o(match_a_o), .match_b_o(match_b_o), .match_c_o(match_c_o)
    );

    task automatic check(input string req, input int act, input int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // reset with quiet inputs, then one enable pulse
    task automatic start(input logic [1:0] src);
        rst_n = 1'b0; tick_i = 1'b1; sw_trig_i = 1'b0; en_cmd_i = 1'b0;
        xc_i = '0; b_in_i = 1'b0; cfg_wave_sel_i = 2'd0; cfg_evt_edge_i = 2'd0;
        cfg_evt_src_i = src; cfg_trig_en_i = 1'b0; cfg_stop_c_i = 1'b0;
        cfg_dis_c_i = 1'b0; cfg_a_match_i = 2'd0; cfg_a_evt_i = 2'd0;
        cfg_b_match_i = 2'd0; ra_i = 16'h8000; rb_i = 16'h8000; rc_i = 16'h8000;
        wn(2);
        rst_n = 1'b1;
        wn(1);
    endtask

    task automatic pulse_en;
        en_cmd_i = 1'b1; wn(1); en_cmd_i = 1'b0;
    endtask

    // after this, the k-th following negedge sees cnt == k-1
    task automatic pulse_sw;
        sw_trig_i = 1'b1; wn(1); sw_trig_i = 1'b0;
    endtask

    task automatic t_reset;
        start(2'd1);
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 pins", int'({a_out_o, b_out_o}), 0);
        check("R1 flags", int'({match_a_o, match_b_o, match_c_o}), 0);
        pulse_sw; wn(4);
        check("R1 clock disabled after reset", int'(cnt_o), 0);
    endtask

    task automatic t_up_gate;
        start(2'd1);
        pulse_en; pulse_sw; wn(1);
        check("R2 load zero", int'(cnt_o), 0);
        wn(3);
        check("R3 up count", int'(cnt_o), 3);
        tick_i = 1'b0; wn(3);
        check("R2 no tick holds", int'(cnt_o), 3);
        tick_i = 1'b1; wn(1);
        check("R2 tick resumes", int'(cnt_o), 4);
    endtask

    task automatic t_updown;
        int exp_seq[8] = '{0, 1, 2, 3, 2, 1, 0, 1};
        start(2'd1);
        cfg_wave_sel_i = 2'd1; rc_i = 16'd3;
        pulse_en; pulse_sw;
        for (int k = 0; k < 8; k++) begin
            wn(1);
            check("R4 updown seq", int'(cnt_o), exp_seq[k]);
            if (k == 3) check("R13 C flag", int'(match_c_o), 1);
            if (k == 4) check("R13 C flag one cycle", int'(match_c_o), 0);
        end
    endtask

    task automatic t_auto;
        start(2'd1);
        cfg_wave_sel_i = 2'd3; rc_i = 16'd3;
        pulse_en; pulse_sw; wn(4);
        check("R5 mode3 at C", int'(cnt_o), 3);
        wn(1);
        check("R5 mode3 restart", int'(cnt_o), 0);
        start(2'd1);
        cfg_wave_sel_i = 2'd2; rc_i = 16'd5; ra_i = 16'd2; cfg_a_match_i = 2'd3;
        pulse_en; pulse_sw; wn(3);
        check("R8 toggle count", int'(cnt_o), 2);
        check("R8 A toggled on", int'(a_out_o), 1);
        check("R13 A flag", int'(match_a_o), 1);
        wn(6);
        check("R5 period C+1", int'(cnt_o), 2);
        check("R8 A toggled off", int'(a_out_o), 0);
    endtask

    task automatic t_stop;
        start(2'd1);
        rc_i = 16'd5; cfg_stop_c_i = 1'b1;
        pulse_en; pulse_sw; wn(6);
        check("R6 reach C", int'(cnt_o), 5);
        wn(6);
        check("R6 hold C", int'(cnt_o), 5);
        pulse_sw; wn(2);
        check("R6 restart", int'(cnt_o), 1);
    endtask

    task automatic t_disable;
        start(2'd1);
        rc_i = 16'd4; cfg_dis_c_i = 1'b1;
        pulse_en; pulse_sw; wn(5);
        check("R7 reach C", int'(cnt_o), 4);
        pulse_sw; wn(5);
        check("R7 trigger ignored", int'(cnt_o), 4);
        pulse_en; wn(1);
        check("R7 enable restarts", int'(cnt_o), 0);
        wn(2);
        check("R7 counting", int'(cnt_o), 2);
    endtask

    task automatic t_ext;
        start(2'd1);
        cfg_evt_edge_i = 2'd1; cfg_trig_en_i = 1'b1; cfg_a_evt_i = 2'd1;
        pulse_en; pulse_sw; wn(10);
        check("R9 pre count", int'(cnt_o), 9);
        xc_i[0] = 1'b1; wn(3);
        check("R9 third edge count", int'(cnt_o), 12);
        check("R10 A set by event", int'(a_out_o), 1);
        wn(1);
        check("R10 restart", int'(cnt_o), 0);
        // falling-edge selection on line 2
        start(2'd3);
        cfg_evt_edge_i = 2'd2; cfg_trig_en_i = 1'b1;
        pulse_en; pulse_sw; wn(5);
        xc_i[2] = 1'b1; wn(6);
        check("R9 rising ignored", int'(cnt_o), 10);
        xc_i[2] = 1'b0; wn(4);
        check("R9 falling restarts", int'(cnt_o), 0);
        // restart disabled: only pin A reacts
        start(2'd2);
        cfg_evt_edge_i = 2'd3; cfg_a_evt_i = 2'd3;
        pulse_en; pulse_sw; wn(5);
        xc_i[1] = 1'b1; wn(3);
        check("R10 A toggled", int'(a_out_o), 1);
        wn(3);
        check("R10 counter unaffected", int'(cnt_o), 10);
    endtask

    task automatic t_bpin;
        start(2'd0);
        rb_i = 16'd2; cfg_b_match_i = 2'd1; cfg_evt_edge_i = 2'd1; cfg_trig_en_i = 1'b1;
        check("R11 B input dir", int'(b_oe_o), 0);
        pulse_en; pulse_sw; wn(3);
        check("R11 no B flag", int'(match_b_o), 0);
        wn(2);
        check("R11 B held", int'(b_out_o), 0);
        b_in_i = 1'b1; wn(4);
        check("R11 B pin event restarts", int'(cnt_o), 0);
        start(2'd1);
        rb_i = 16'd2; cfg_b_match_i = 2'd1;
        check("R11 B output dir", int'(b_oe_o), 1);
        pulse_en; pulse_sw; wn(3);
        check("R11 B flag", int'(match_b_o), 1);
        check("R11 B set", int'(b_out_o), 1);
    endtask

    task automatic t_prio;
        start(2'd1);
        rc_i = 16'd8; cfg_stop_c_i = 1'b1; cfg_evt_edge_i = 2'd1; cfg_trig_en_i = 1'b1;
        pulse_en; pulse_sw; wn(6);
        check("R12 pre count", int'(cnt_o), 5);
        xc_i[0] = 1'b1; wn(3);
        check("R12 at C", int'(cnt_o), 8);
        wn(2);
        check("R12 edge beats stop", int'(cnt_o), 1);
    endtask

    initial begin
        #(20 * 150000);
        fails++; runs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        t_reset;
        t_up_gate;
        t_updown;
        t_auto;
        t_stop;
        t_disable;
        t_ext;
        t_bpin;
        t_prio;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule